// File: doc/BRIEF.md
# Partial-Field Word Load Unit

This block moves a sign-magnitude word between a single-port word memory and one accumulator register, touching only a chosen slice of the word. A word has six positions. Position 0 holds the sign (bit 40, 1 = minus) and positions 1 to 5 hold 8-bit bytes, position 1 the most significant. Byte `k` sits at bits `[(5-k)*8+7 : (5-k)*8]`. An operation names a slice by a packed byte `field_spec = 8*L + R`, which selects positions L through R with both ends included. So 0 picks the sign alone, 5 the whole word, 13 the magnitude without its sign and 37 the two low bytes.

A load reads the addressed word and right-justifies the selected bytes into the accumulator. The higher bytes are cleared. The accumulator sign comes from the word only when the slice starts at the sign position. A store performs a read-modify-write. It reads the word, replaces the selected positions with the accumulator's low-order bytes (and its sign when L = 0), and writes the word back. A bad slice or an address past the end of memory is refused with an error pulse. The accumulator can be preset through a side port so that stores have data to write.

Top module: `field_load_store_unit`

## Requirements
- R1: After reset, `acc` is 0, `done`, `err`, `mem_en` and `mem_we` are 0.
- R2: A load sets the accumulator sign (bit 40) to the word's sign when L = 0 and to + (0) when L > 0.
- R3: A load places word byte R in accumulator byte 5, byte R-1 in byte 4 and so on down to position max(L,1). All remaining accumulator bytes become 0.
- R4: A store changes only memory positions L..R of the addressed word. The sign position is written (from `acc` bit 40) only when L = 0, and every other position keeps its old value.
- R5: A store writes accumulator byte 5 into memory byte R, accumulator byte 4 into byte R-1, and so on for each selected byte position.
- R6: A `field_spec` with L > R or R > 5 raises `done` and `err` together for one cycle, one cycle after the start edge. No memory access is issued and `acc` does not change.
- R7: An address of 4000 or more is refused in the same way as R6.
- R8: A valid load issues one memory read in the cycle after the start edge. The accumulator takes the new value at the second edge after start, and `done` is high for exactly the following cycle.
- R9: A valid store issues one read (`mem_en`=1, `mem_we`=0) in the cycle after the start edge and one write (`mem_we`=1) to the same address in the next cycle. It then pulses `done` for one cycle.
- R10: `start` is ignored while an operation is in progress.
- R11: `acc_set` loads `acc_set_val` into `acc` on the next edge, except on the edge where a load completes, when the load result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_store | input | 1 | 1 = store accumulator to memory, 0 = load |
| field_spec | input | 8 | Packed slice 8*L+R |
| addr | input | 12 | Word address |
| acc_set | input | 1 | Preset strobe for the accumulator |
| acc_set_val | input | 41 | Preset value |
| acc | output | 41 | Accumulator contents |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse, coincides with done |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 41 | Memory write data |
| mem_rdata | input | 41 | Memory read data, valid one cycle after a read |

## Verification
Each result has a fixed arrival cycle. A refusal shows on `done`/`err` one edge after the start edge. The read request appears one edge after start. A store's write request appears two edges after start. The accumulator update and `done` of a valid operation appear three edges after start, counting the edge that samples `start`. The bench drives and samples on falling edges, and its per-operation task checks each of these cycles in turn. It also checks that no extra memory request or `done` pulse shows up in the cycle after completion. Expected words come from mask-and-shift arithmetic on 40-bit magnitudes in the bench, not from per-byte lanes.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  localparam int NBYTES   = 5;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = NBYTES * BYTE_W + 1;
  localparam int SIGN_BIT = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_FINISH = 2'd2
  } state_e;

  // Byte at position k (1 = most significant); 0 for any other k.
  function automatic byte_t byte_of(word_t w, int k);
    byte_t b;
    case (k)
      1:       b = w[4*BYTE_W +: BYTE_W];
      2:       b = w[3*BYTE_W +: BYTE_W];
      3:       b = w[2*BYTE_W +: BYTE_W];
      4:       b = w[1*BYTE_W +: BYTE_W];
      5:       b = w[0*BYTE_W +: BYTE_W];
      default: b = '0;
    endcase
    return b;
  endfunction

  // First byte position covered by a slice starting at l.
  function automatic int first_byte(int l);
    return (l == 0) ? 1 : l;
  endfunction

  // Slice is legal when it stays inside the word and is ordered.
  function automatic logic spec_legal(int l, int r);
    return (r <= NBYTES) && (l <= r);
  endfunction

  // Word position that feeds register lane j on a load.
  function automatic int load_source(int j, int r);
    return j + r - NBYTES;
  endfunction

  // Register lane that feeds word position k on a store.
  function automatic int store_source(int k, int r);
    return k + NBYTES - r;
  endfunction
endpackage

// File: rtl/pfl_field_decode.sv
module pfl_field_decode #(
  parameter int MEM_WORDS = 4000,
  parameter int AW        = 12
) (
  input  logic [7:0]    field_spec,
  input  logic [AW-1:0] addr,
  output logic [2:0]    l_pos,
  output logic [2:0]    r_pos,
  output logic          spec_ok,
  output logic          addr_ok
);
  import pfl_pkg::*;

  logic [4:0] l_raw;
  logic [2:0] r_raw;

  assign l_raw   = field_spec[7:3];
  assign r_raw   = field_spec[2:0];
  assign spec_ok = spec_legal(int'(l_raw), int'(r_raw));
  assign addr_ok = int'(addr) < MEM_WORDS;
  assign l_pos   = l_raw[2:0];
  assign r_pos   = r_raw;
endmodule

// File: rtl/pfl_ctrl.sv
module pfl_ctrl #(
  parameter int MEM_WORDS = 4000,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_store,
  input  logic [AW-1:0] addr,
  input  logic [2:0]    l_in,
  input  logic [2:0]    r_in,
  input  logic          spec_ok,
  input  logic          addr_ok,
  output logic [2:0]    l_cap,
  output logic [2:0]    r_cap,
  output logic          acc_upd,
  output logic          done,
  output logic          err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr
);
  import pfl_pkg::*;

  state_e        st;
  logic          store_cap;
  logic [AW-1:0] addr_cap;
  logic          done_q, err_q;
  logic          accept, reject;

  assign accept = (st == ST_IDLE) && start && spec_ok && addr_ok;
  assign reject = (st == ST_IDLE) && start && !(spec_ok && addr_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      store_cap <= 1'b0;
      addr_cap  <= '0;
      l_cap     <= '0;
      r_cap     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            store_cap <= op_store;
            addr_cap  <= addr;
            l_cap     <= l_in;
            r_cap     <= r_in;
            st        <= ST_READ;
          end else if (reject) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end
        end
        ST_READ:   st <= ST_FINISH;
        ST_FINISH: begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign mem_en   = (st == ST_READ) || ((st == ST_FINISH) && store_cap);
  assign mem_we   = (st == ST_FINISH) && store_cap;
  assign acc_upd  = (st == ST_FINISH) && !store_cap;
  assign mem_addr = addr_cap;
  assign done     = done_q;
  assign err      = err_q;

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a refusal is always reported together with done
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R6: a refused request produces no memory access and reports error next
  a_r6_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (err && !mem_en));
  // R9: a write is always preceded by a read of the same word
  a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_en && !mem_we) && (mem_addr == $past(mem_addr))));
  // R7: accepted requests only reach addresses inside the memory
  a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (int'(mem_addr) < MEM_WORDS));
  // R10: an accepted request is followed by a read, never a fresh accept
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mem_en && !mem_we && !accept));
endmodule

// File: rtl/pfl_datapath.sv
module pfl_datapath (
  input  pfl_pkg::word_t mem_word,
  input  pfl_pkg::word_t acc_word,
  input  logic [2:0]     l_pos,
  input  logic [2:0]     r_pos,
  output pfl_pkg::word_t load_word,
  output pfl_pkg::word_t store_word
);
  import pfl_pkg::*;

  assign load_word[SIGN_BIT]  = (l_pos == 3'd0) ? mem_word[SIGN_BIT] : 1'b0;
  assign store_word[SIGN_BIT] = (l_pos == 3'd0) ? acc_word[SIGN_BIT]
                                                : mem_word[SIGN_BIT];

  for (genvar g = 1; g <= NBYTES; g++) begin : g_lane
    byte_t ld_b, st_b;

    always_comb begin
      int lo, src_ld, src_st;
      lo     = first_byte(int'(l_pos));
      src_ld = load_source(g, int'(r_pos));
      src_st = store_source(g, int'(r_pos));
      ld_b   = (src_ld >= lo && src_ld <= int'(r_pos))
               ? byte_of(mem_word, src_ld) : '0;
      st_b   = (g >= lo && g <= int'(r_pos))
               ? byte_of(acc_word, src_st) : byte_of(mem_word, g);
    end

    assign load_word[(NBYTES-g)*BYTE_W +: BYTE_W]  = ld_b;
    assign store_word[(NBYTES-g)*BYTE_W +: BYTE_W] = st_b;
  end
endmodule

// File: rtl/field_load_store_unit.sv
module field_load_store_unit #(
  parameter int MEM_WORDS = 4000,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_store,
  input  logic [7:0]    field_spec,
  input  logic [AW-1:0] addr,
  input  logic          acc_set,
  input  logic [40:0]   acc_set_val,
  output logic [40:0]   acc,
  output logic          done,
  output logic          err,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [40:0]   mem_wdata,
  input  logic [40:0]   mem_rdata
);
  import pfl_pkg::*;

  logic [2:0] l_dec, r_dec, l_cap, r_cap;
  logic       spec_ok, addr_ok, acc_upd;
  word_t      acc_q, load_word, store_word;

  pfl_field_decode #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_decode (
    .field_spec (field_spec),
    .addr       (addr),
    .l_pos      (l_dec),
    .r_pos      (r_dec),
    .spec_ok    (spec_ok),
    .addr_ok    (addr_ok)
  );

  pfl_ctrl #(.MEM_WORDS(MEM_WORDS), .AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_store (op_store),
    .addr     (addr),
    .l_in     (l_dec),
    .r_in     (r_dec),
    .spec_ok  (spec_ok),
    .addr_ok  (addr_ok),
    .l_cap    (l_cap),
    .r_cap    (r_cap),
    .acc_upd  (acc_upd),
    .done     (done),
    .err      (err),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
  );

  pfl_datapath u_dp (
    .mem_word   (mem_rdata),
    .acc_word   (acc_q),
    .l_pos      (l_cap),
    .r_pos      (r_cap),
    .load_word  (load_word),
    .store_word (store_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (acc_upd) acc_q <= load_word;
    else if (acc_set) acc_q <= acc_set_val;
  end

  assign acc       = acc_q;
  assign mem_wdata = store_word;

  // R11: the accumulator moves only on a load completion or a preset
  a_r11_acc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(acc_upd || acc_set));
  // R2: a load whose slice skips the sign always yields a plus sign
  a_r2_plus_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_upd && l_cap != 3'd0) |=> !acc_q[SIGN_BIT]);
endmodule

// File: tb/test_field_load_store_unit.sv
module test_field_load_store_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 4000;

  logic        clk = 1'b0;
  logic        rst_n, start, op_store, acc_set;
  logic [7:0]  field_spec;
  logic [11:0] addr;
  logic [40:0] acc_set_val, acc, mem_wdata, mem_rdata;
  logic        done, err, mem_en, mem_we;
  logic [11:0] mem_addr;

  logic [40:0] mem [WORDS];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_load_store_unit i_field_load_store_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
    .field_spec(field_spec), .addr(addr), .acc_set(acc_set),
    .acc_set_val(acc_set_val), .acc(acc), .done(done), .err(err),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en && int'(mem_addr) < WORDS) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [40:0] model_load(logic [40:0] w, int l, int r);
    logic [63:0] mag, m;
    int lo, n;
    lo  = (l == 0) ? 1 : l;
    n   = (r == 0) ? 0 : r - lo + 1;
    m   = (64'd1 << (8*n)) - 64'd1;
    mag = ({24'd0, w[39:0]} >> (8*(5-r))) & m;
    return {(l == 0) ? w[40] : 1'b0, mag[39:0]};
  endfunction

  function automatic logic [40:0] model_store(logic [40:0] old, logic [40:0] a,
                                              int l, int r);
    logic [63:0] m, v, res;
    int lo, n;
    lo  = (l == 0) ? 1 : l;
    n   = (r == 0) ? 0 : r - lo + 1;
    m   = ((64'd1 << (8*n)) - 64'd1) << (8*(5-r));
    v   = ({24'd0, a[39:0]} << (8*(5-r))) & m;
    res = ({24'd0, old[39:0]} & ~m) | v;
    return {(l == 0) ? a[40] : old[40], res[39:0]};
  endfunction

  task automatic preset(input logic [40:0] v);
    acc_set = 1'b1; acc_set_val = v;
    @(negedge clk);
    acc_set = 1'b0;
    check(acc == v, "R11 preset", acc, v);
  endtask

  // One valid operation, checked cycle by cycle.
  task automatic run_ok(input bit st, input int l, input int r, input int a,
                        input string req);
    logic [40:0] exp_acc, exp_mem;
    exp_acc = st ? acc : model_load(mem[a], l, r);
    exp_mem = st ? model_store(mem[a], acc, l, r) : mem[a];
    start = 1'b1; op_store = st; field_spec = 8'(8*l + r); addr = 12'(a);
    @(negedge clk);
    start = 1'b0;
    check(mem_en && !mem_we && mem_addr == 12'(a) && !done,
          st ? "R9 read" : "R8 read", {mem_en, mem_we, done}, 3'b100);
    @(negedge clk);
    check(mem_we == st && !done, st ? "R9 write" : "R8 no write",
          mem_we, st);
    @(negedge clk);
    check(done && !err, st ? "R9 done" : "R8 done", {done, err}, 2'b10);
    check(acc == exp_acc, req, acc, exp_acc);
    check(mem[a] == exp_mem, req, mem[a], exp_mem);
    @(negedge clk);
    check(!done && !mem_en, "R8 single pulse", {done, mem_en}, 2'b00);
  endtask

  task automatic run_bad(input bit st, input int spec, input int a,
                         input string req);
    logic [40:0] acc0, m0;
    acc0 = acc; m0 = mem[1];
    start = 1'b1; op_store = st; field_spec = 8'(spec); addr = 12'(a);
    @(negedge clk);
    start = 1'b0;
    check(done && err && !mem_en, req, {done, err, mem_en}, 3'b110);
    @(negedge clk);
    check(!done && !err && !mem_en, req, {done, err, mem_en}, 3'b000);
    check(acc == acc0 && mem[1] == m0, req, acc, acc0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; op_store = 1'b0; acc_set = 1'b0;
    field_spec = '0; addr = '0; acc_set_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(acc == '0 && !done && !err && !mem_en && !mem_we, "R1 reset",
          {acc, done, err, mem_en, mem_we}, 45'd0);
  endtask

  task automatic t_loads;
    run_ok(0, 0, 5, 7, "R3 load (0:5)");
    run_ok(0, 0, 5, 8, "R2 load (0:5) minus sign");
    run_ok(0, 1, 5, 8, "R2 load (1:5) forces plus");
    run_ok(0, 4, 5, 8, "R3 load (4:5)");
    run_ok(0, 2, 3, 7, "R3 load (2:3)");
    run_ok(0, 0, 0, 8, "R2 load (0:0) sign only");
    run_ok(0, 3, 3, 8, "R3 load (3:3)");
    run_ok(0, 0, 2, 8, "R3 load (0:2)");
  endtask

  task automatic t_stores;
    preset({1'b1, 40'hA1_B2_C3_D4_E5});
    run_ok(1, 0, 5, 20, "R5 store (0:5)");
    run_ok(1, 0, 0, 21, "R4 store (0:0) sign only");
    run_ok(1, 4, 5, 22, "R5 store (4:5)");
    run_ok(1, 1, 1, 23, "R4 store (1:1) sign kept");
    run_ok(1, 2, 4, 3999, "R5 store (2:4) last word");
    run_ok(1, 0, 3, 24, "R4 store (0:3)");
  endtask

  task automatic t_errors;
    run_bad(0, 8*3 + 2, 5, "R6 L>R load");
    run_bad(1, 6, 5, "R6 R=6 store");
    run_bad(1, 8*7 + 7, 5, "R6 (7:7)");
    run_bad(0, 5, 4000, "R7 addr 4000");
    run_bad(1, 5, 4095, "R7 addr 4095");
  endtask

  task automatic t_busy;
    logic [40:0] exp_acc, m30;
    exp_acc = model_load(mem[9], 0, 5);
    m30 = mem[30];
    start = 1'b1; op_store = 1'b0; field_spec = 8'd5; addr = 12'd9;
    @(negedge clk);
    op_store = 1'b1; field_spec = 8'd5; addr = 12'd30;
    @(negedge clk);
    check(mem_addr == 12'd9, "R10 addr held", mem_addr, 12'd9);
    acc_set = 1'b1; acc_set_val = 41'h155;
    @(negedge clk);
    start = 1'b0; acc_set = 1'b0;
    check(done && acc == exp_acc, "R11 load beats preset", acc, exp_acc);
    @(negedge clk);
    check(!done && !mem_en && mem[30] == m30, "R10 start ignored",
          {done, mem_en}, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++)
      mem[i] = {i[0], 8'(i*3+1), 8'(i*5+2), 8'(i*7+3), 8'(i*11+4), 8'(i*13+5)};
    mem[8] = {1'b1, 40'h11_22_33_44_55};
    t_reset();
    t_loads();
    t_stores();
    t_errors();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule